// File: doc/BRIEF.md
# DMA Descriptor Execution Sequencer

This block runs one DMA channel from a list of 16-byte command descriptors held in memory. It starts when software sets the command pointer and issues a go pulse while the run level is high. It then repeats a fixed loop: fetch the descriptor at the pointer, decode the command word, and carry out the operation. The operation can be a stream transfer, a 4-byte device-register load or store, a no-op, or a stop. After that it applies the wait, interrupt and branch rules, writes back the residual count and status, and moves the pointer.

Each descriptor is little-endian. Bytes 0-1 hold the requested count, bytes 2-3 the command word, bytes 4-7 the data address, bytes 8-11 the branch target, bytes 12-13 the residual count and bytes 14-15 the transfer status. The command word packs these fields:

- the opcode in bits [15:12];
- a stream or space key in bits [10:8];
- three 2-bit condition selectors: interrupt in [5:4], branch in [3:2] and wait in [1:0].

Each selector means 0 = never, 1 = when the condition bit is 1, 2 = when it is 0, 3 = always. The condition bit for a rule is 1 when `(status[7:0] & sel[7:0]) == (sel[15:8] & sel[7:0])`, using that rule's 16-bit select input. Here status[7:0] is the live device status input.

Top module: `dbseq_top`

## Requirements
- R1: After reset, ACTIVE (status bit 10), DEAD (bit 11) and BT (bit 8) read 0. No fetch, transfer, write-back or interrupt is requested.
- R2: A go pulse sets ACTIVE and clears DEAD and BT. Fetching starts only while the run input is high. A fetch presents the command pointer and holds it stable until the fetch is acknowledged.
- R3: A command-pointer write is ignored while ACTIVE is set.
- R4: Opcodes 0-3 (output-more, output-last, input-more, input-last), 4 (store-word) and 5 (load-word) issue one transfer request. The request carries the descriptor's opcode, key, data address and requested count.
- R5: These kill the channel (DEAD set, ACTIVE cleared, no transfer): an input opcode (2 or 3) with a zero data address or a key above 3, or any opcode from 8 to 15.
- R6: A store-word or load-word with a key below 5 kills the channel. Keys 5 to 7 are accepted.
- R7: After a transfer completes, the channel holds while the wait rule is true. During the hold it does no write-back and does not advance.
- R8: Write-back goes to command pointer + 12. The data is {status[15:0], residual[15:0]}. The status bits are: RUN at bit 15, DEAD at 11, ACTIVE at 10, BT at 8 and device status at [7:0].
- R9: The interrupt output pulses for exactly one cycle at the end of a descriptor when the interrupt rule is true, and never otherwise.
- R10: When the branch rule is true, the pointer loads the branch target and BT is set. Otherwise the pointer advances by 16 and BT is cleared.
- R11: Stop clears ACTIVE and leaves the pointer unchanged. No-op applies only the interrupt and branch rules, with no transfer and no write-back.
- R12: Descriptors execute back to back while run and ACTIVE are high. With run low, no new descriptor is fetched.
- R13: A transfer request stays asserted until it is completed. Fetch, transfer and write-back never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runIn | input | 1 | Channel run level |
| goIn | input | 1 | Start pulse: set ACTIVE, clear DEAD and BT |
| ptrWrEn | input | 1 | Command-pointer write strobe |
| ptrWrData | input | ADDR_W | New command pointer |
| devStat | input | 8 | Live device status bits |
| waitSel | input | 16 | Wait condition select (value[15:8], mask[7:0]) |
| intrSel | input | 16 | Interrupt condition select |
| branchSel | input | 16 | Branch condition select |
| statusOut | output | 16 | Channel status |
| fetchReq | output | 1 | Descriptor fetch request |
| fetchAddr | output | ADDR_W | Descriptor address |
| fetchValid | input | 1 | Fetch data valid |
| fetchData | input | 128 | Whole descriptor, byte 0 in bits [7:0] |
| xferReq | output | 1 | Transfer request |
| xferOp | output | 4 | Opcode of the transfer |
| xferKey | output | 3 | Stream or space key |
| xferAddr | output | 32 | Data address |
| xferCount | output | 16 | Requested byte count |
| xferDone | input | 1 | Transfer complete |
| xferResid | input | 16 | Residual count reported at completion |
| wbValid | output | 1 | Status write-back strobe |
| wbAddr | output | ADDR_W | Write-back address |
| wbData | output | 32 | Write-back word |
| irqOut | output | 1 | Interrupt pulse |

## Verification
The bench uses the default ADDR_W of 32 with a 16-slot descriptor window, and unused slots hold stop descriptors. That keeps every program short, so the bench can sweep all six transfer opcodes against all eight keys, checking each accept or kill outcome and its write-back word. It also sweeps all sixteen interrupt-by-branch selector pairs against both condition values. A held wait and a pointer write made during that hold, a chained run, and a run-low start are driven by hand.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;
  localparam int DESC_BYTES = 16;
  localparam int WB_OFFSET  = 12;

  localparam logic [3:0] OP_IN_LAST = 4'd3;
  localparam logic [3:0] OP_STORE   = 4'd4;
  localparam logic [3:0] OP_LOAD    = 4'd5;
  localparam logic [3:0] OP_NOP     = 4'd6;
  localparam logic [3:0] OP_STOP    = 4'd7;

  localparam logic [2:0] KEY_LAST_STREAM = 3'd3;
  localparam logic [2:0] KEY_REG_SPACE   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_XFER, ST_HOLD, ST_FINAL
  } seqState_t;

  typedef struct packed {
    logic ldDesc;
    logic ldResid;
    logic kill;
    logic halt;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/dbseq_datapath.sv
module dbseq_datapath
  import dbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              goIn,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic              runIn,
  input  logic [7:0]        devStat,
  input  logic [15:0]       waitSel,
  input  logic [15:0]       intrSel,
  input  logic [15:0]       branchSel,
  input  logic [127:0]      fetchData,
  input  logic [15:0]       xferResid,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic [3:0]        descOp,
  output logic [2:0]        descKey,
  output logic [31:0]       descAddr,
  output logic [15:0]       descCount,
  output logic              waitHit,
  output logic              intrHit,
  output logic              branchHit,
  output logic              active,
  output logic [15:0]       statusOut,
  output logic [31:0]       wbData
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [15:0] cmdWord;
  logic [31:0] descDep;
  logic [15:0] residReg;
  logic        dead;
  logic        btFlag;

  function automatic logic modeHit(input logic [1:0] mode, input logic [15:0] sel,
                                   input logic [7:0] st);
    logic c;
    c = ((st & sel[7:0]) == (sel[15:8] & sel[7:0]));
    case (mode)
      2'd0:    return 1'b0;
      2'd1:    return c;
      2'd2:    return !c;
      default: return 1'b1;
    endcase
  endfunction

  assign descOp    = cmdWord[15:12];
  assign descKey   = cmdWord[10:8];
  assign intrHit   = modeHit(cmdWord[5:4], intrSel, devStat);
  assign branchHit = modeHit(cmdWord[3:2], branchSel, devStat);
  assign waitHit   = modeHit(cmdWord[1:0], waitSel, devStat);
  assign statusOut = {runIn, 3'b000, dead, active, 1'b0, btFlag, devStat};
  assign wbData    = {statusOut, residReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPtr    <= '0;
      cmdWord   <= '0;
      descAddr  <= '0;
      descDep   <= '0;
      descCount <= '0;
      residReg  <= '0;
      active    <= 1'b0;
      dead      <= 1'b0;
      btFlag    <= 1'b0;
    end else begin
      if (ptrWrEn && !active) cmdPtr <= ptrWrData;
      if (goIn) begin
        active <= 1'b1;
        dead   <= 1'b0;
        btFlag <= 1'b0;
      end
      if (strobe.ldDesc) begin
        descCount <= fetchData[15:0];
        cmdWord   <= fetchData[31:16];
        descAddr  <= fetchData[63:32];
        descDep   <= fetchData[95:64];
      end
      if (strobe.ldResid) residReg <= xferResid;
      if (strobe.kill) begin
        dead   <= 1'b1;
        active <= 1'b0;
      end
      if (strobe.halt) active <= 1'b0;
      if (strobe.finish) begin
        if (branchHit) begin
          cmdPtr <= descDep[ADDR_W-1:0];
          btFlag <= 1'b1;
        end else begin
          cmdPtr <= cmdPtr + STEP;
          btFlag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dbseq_ctrl.sv
module dbseq_ctrl
  import dbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runIn,
  input  logic       active,
  input  logic [3:0] descOp,
  input  logic [2:0] descKey,
  input  logic       addrZero,
  input  logic       fetchValid,
  input  logic       xferDone,
  input  logic       waitHit,
  input  logic       intrHit,
  output seqStrobe_t strobe,
  output logic       fetchReq,
  output logic       xferReq,
  output logic       wbValid,
  output logic       irqOut
);
  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strobe   = '0;
    fetchReq = 1'b0;
    xferReq  = 1'b0;
    wbValid  = 1'b0;
    irqOut   = 1'b0;
    case (state)
      ST_IDLE: if (active && runIn) nxt = ST_FETCH;
      ST_FETCH: begin
        fetchReq = 1'b1;
        if (fetchValid) begin
          strobe.ldDesc = 1'b1;
          nxt = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (descOp <= OP_IN_LAST) begin
          if (descOp[1] && (addrZero || descKey > KEY_LAST_STREAM)) begin
            strobe.kill = 1'b1;
            nxt = ST_IDLE;
          end else nxt = ST_XFER;
        end else if (descOp == OP_STORE || descOp == OP_LOAD) begin
          if (descKey < KEY_REG_SPACE) begin
            strobe.kill = 1'b1;
            nxt = ST_IDLE;
          end else nxt = ST_XFER;
        end else if (descOp == OP_NOP) begin
          nxt = ST_FINAL;
        end else if (descOp == OP_STOP) begin
          strobe.halt = 1'b1;
          nxt = ST_IDLE;
        end else begin
          strobe.kill = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_XFER: begin
        xferReq = 1'b1;
        if (xferDone) begin
          strobe.ldResid = 1'b1;
          nxt = ST_HOLD;
        end
      end
      ST_HOLD: if (!waitHit) nxt = ST_FINAL;
      ST_FINAL: begin
        wbValid       = (descOp != OP_NOP);
        irqOut        = intrHit;
        strobe.finish = 1'b1;
        nxt = runIn ? ST_FETCH : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dbseq_top.sv
module dbseq_top
  import dbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runIn,
  input  logic              goIn,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic [7:0]        devStat,
  input  logic [15:0]       waitSel,
  input  logic [15:0]       intrSel,
  input  logic [15:0]       branchSel,
  output logic [15:0]       statusOut,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic [127:0]      fetchData,
  output logic              xferReq,
  output logic [3:0]        xferOp,
  output logic [2:0]        xferKey,
  output logic [31:0]       xferAddr,
  output logic [15:0]       xferCount,
  input  logic              xferDone,
  input  logic [15:0]       xferResid,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [31:0]       wbData,
  output logic              irqOut
);
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] cmdPtr;
  logic              waitHit, intrHit, branchHit, active;

  dbseq_datapath #(.ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .goIn(goIn), .ptrWrEn(ptrWrEn),
    .ptrWrData(ptrWrData), .runIn(runIn), .devStat(devStat), .waitSel(waitSel),
    .intrSel(intrSel), .branchSel(branchSel), .fetchData(fetchData),
    .xferResid(xferResid), .cmdPtr(cmdPtr), .descOp(xferOp), .descKey(xferKey),
    .descAddr(xferAddr), .descCount(xferCount), .waitHit(waitHit),
    .intrHit(intrHit), .branchHit(branchHit), .active(active),
    .statusOut(statusOut), .wbData(wbData)
  );

  dbseq_ctrl ctl (
    .clk(clk), .rstN(rstN), .runIn(runIn), .active(active), .descOp(xferOp),
    .descKey(xferKey), .addrZero(xferAddr == 32'd0), .fetchValid(fetchValid),
    .xferDone(xferDone), .waitHit(waitHit), .intrHit(intrHit), .strobe(strobe),
    .fetchReq(fetchReq), .xferReq(xferReq), .wbValid(wbValid), .irqOut(irqOut)
  );

  assign fetchAddr = cmdPtr;
  assign wbAddr    = cmdPtr + ADDR_W'(WB_OFFSET);
endmodule

// File: rtl/dbseq_checker.sv
module dbseq_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              runIn,
  input logic [15:0]       statusOut,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid,
  input logic              xferReq,
  input logic              xferDone,
  input logic              wbValid,
  input logic              irqOut
);
  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchValid |=> fetchReq && $stable(fetchAddr));

  assert_xfer_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferDone |=> xferReq);

  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fetchReq, xferReq, wbValid}));

  assert_wb_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> statusOut[10]);

  assert_kill_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[11]) |-> !statusOut[10]);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);

  assert_run_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !runIn && !fetchReq |=> !fetchReq);
endmodule

bind dbseq_top dbseq_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .runIn(runIn), .statusOut(statusOut),
  .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
  .xferReq(xferReq), .xferDone(xferDone), .wbValid(wbValid), .irqOut(irqOut)
);

// File: tb/tb_dbseq_top.sv
module tb_dbseq_top;
  logic         clk = 0;
  logic         rstN = 0;
  logic         runIn = 0, goIn = 0, ptrWrEn = 0;
  logic [31:0]  ptrWrData = 0;
  logic [7:0]   devStat = 0;
  logic [15:0]  waitSel = 16'h0101, intrSel = 16'h0101, branchSel = 16'h0101;
  logic [15:0]  statusOut;
  logic         fetchReq, fetchValid, xferReq, xferDone, wbValid, irqOut;
  logic [31:0]  fetchAddr, xferAddr, wbAddr, wbData;
  logic [127:0] fetchData;
  logic [3:0]   xferOp;
  logic [2:0]   xferKey;
  logic [15:0]  xferCount;
  logic [15:0]  residVal = 0;
  logic [127:0] mem [16];

  int errors = 0, checks = 0;
  int fetchCnt, xferCnt, wbCnt, irqCnt;
  logic [31:0] lastFetch, lastAddr, lastWbA, lastWbD;
  logic [3:0]  lastOp;
  logic [2:0]  lastKey;
  logic [15:0] lastCount;

  always #10 clk = ~clk;

  assign fetchValid = fetchReq;
  assign fetchData  = mem[fetchAddr[7:4]];
  assign xferDone   = xferReq;

  dbseq_top dut (
    .clk(clk), .rstN(rstN), .runIn(runIn), .goIn(goIn), .ptrWrEn(ptrWrEn),
    .ptrWrData(ptrWrData), .devStat(devStat), .waitSel(waitSel),
    .intrSel(intrSel), .branchSel(branchSel), .statusOut(statusOut),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .fetchData(fetchData), .xferReq(xferReq), .xferOp(xferOp), .xferKey(xferKey),
    .xferAddr(xferAddr), .xferCount(xferCount), .xferDone(xferDone),
    .xferResid(residVal), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .irqOut(irqOut)
  );

  always @(negedge clk) if (rstN) begin
    if (fetchReq) begin fetchCnt++; lastFetch = fetchAddr; end
    if (xferReq && xferDone) begin
      xferCnt++; lastOp = xferOp; lastKey = xferKey;
      lastAddr = xferAddr; lastCount = xferCount;
    end
    if (wbValid) begin wbCnt++; lastWbA = wbAddr; lastWbD = wbData; end
    if (irqOut) irqCnt++;
  end

  function automatic logic [127:0] mkDesc(input logic [3:0] op, input logic [2:0] key,
      input logic [5:0] modes, input logic [15:0] cnt, input logic [31:0] addr,
      input logic [31:0] dep);
    logic [15:0] cmd;
    cmd = {op, 1'b0, key, 2'b00, modes};
    return {16'h0, 16'h0, dep, addr, cmd, cnt};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 16; i++) mem[i] = mkDesc(4'd7, 3'd0, 6'd0, 16'd0, 32'd0, 32'd0);
  endtask

  task automatic startProg(input logic [31:0] start);
    fetchCnt = 0; xferCnt = 0; wbCnt = 0; irqCnt = 0;
    lastFetch = 0; lastWbA = 0; lastWbD = 0;
    @(negedge clk); ptrWrEn = 1; ptrWrData = start;
    @(negedge clk); ptrWrEn = 0; goIn = 1;
    @(negedge clk); goIn = 0;
  endtask

  task automatic waitStop();
    int n = 0;
    while (statusOut[10] && n < 3000) begin @(negedge clk); n++; end
    chk("R12 channel reached stop", {31'd0, statusOut[10]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    chk("R1 reset status", {16'd0, statusOut}, 32'd0);
    chk("R1 reset requests", {28'd0, fetchReq, xferReq, wbValid, irqOut}, 32'd0);
    rstN = 1; runIn = 1;
    @(negedge clk);

    // R4 R5 R6 R8: opcode by key sweep
    for (int op = 0; op < 6; op++) begin
      for (int key = 0; key < 8; key++) begin
        logic kill;
        clearMem();
        mem[0] = mkDesc(op[3:0], key[2:0], 6'd0, 16'h40 + 16'(op),
                        32'h1000 + 32'(key) * 16, 32'd0);
        residVal = 16'(op * 8 + key + 1);
        kill = ((op == 2 || op == 3) && key > 3) || (op >= 4 && key < 5);
        startProg(32'd0);
        waitStop();
        if (kill) begin
          chk(op >= 4 ? "R6 kill dead bit" : "R5 kill dead bit",
              {31'd0, statusOut[11]}, 32'd1);
          chk("R5 kill no transfer", xferCnt, 0);
          chk("R5 kill no writeback", wbCnt, 0);
        end else begin
          chk("R4 xfer op", {28'd0, lastOp}, 32'(op));
          chk("R4 xfer key", {29'd0, lastKey}, 32'(key));
          chk("R4 xfer addr", lastAddr, 32'h1000 + 32'(key) * 16);
          chk("R4 xfer count", {16'd0, lastCount}, 32'h40 + 32'(op));
          chk("R8 wb addr", lastWbA, 32'h0C);
          chk("R8 wb data", lastWbD, {16'h8400, 16'(op * 8 + key + 1)});
          chk("R10 advance to stop", lastFetch, 32'h10);
          chk("R9 no irq when never", irqCnt, 0);
        end
      end
    end

    // R5: input with zero address, undefined opcode
    clearMem();
    mem[0] = mkDesc(4'd2, 3'd0, 6'd0, 16'd4, 32'd0, 32'd0);
    startProg(32'd0); waitStop();
    chk("R5 zero address kill", {30'd0, statusOut[11:10]}, 32'd2);
    chk("R5 zero address no xfer", xferCnt, 0);
    clearMem();
    mem[0] = mkDesc(4'd9, 3'd0, 6'd0, 16'd4, 32'h10, 32'd0);
    startProg(32'd0); waitStop();
    chk("R5 bad opcode kill", {31'd0, statusOut[11]}, 32'd1);

    // R7 R3 R2: wait hold, pointer write ignored, go clears dead
    clearMem();
    mem[0] = mkDesc(4'd1, 3'd0, 6'b000001, 16'h20, 32'h2000, 32'd0);
    residVal = 16'h0033;
    devStat = 8'h01;
    startProg(32'd0);
    repeat (20) @(negedge clk);
    chk("R2 go clears dead", {31'd0, statusOut[11]}, 32'd0);
    chk("R7 hold no writeback", wbCnt, 0);
    chk("R7 hold transfer done once", xferCnt, 1);
    ptrWrEn = 1; ptrWrData = 32'h80;
    @(negedge clk); ptrWrEn = 0;
    devStat = 8'h00;
    waitStop();
    chk("R7 writeback after release", wbCnt, 1);
    chk("R8 wb data after wait", lastWbD, 32'h8400_0033);
    chk("R3 pointer write ignored", lastFetch, 32'h10);

    // R9 R10 R11: no-op interrupt by branch sweep
    for (int im = 0; im < 4; im++) begin
      for (int bm = 0; bm < 4; bm++) begin
        for (int c = 0; c < 2; c++) begin
          logic iHit, bHit;
          clearMem();
          mem[0] = mkDesc(4'd6, 3'd0, {im[1:0], bm[1:0], 2'b00}, 16'd0, 32'd0, 32'h40);
          devStat = c[7:0];
          iHit = (im == 3) || (im == 1 && c == 1) || (im == 2 && c == 0);
          bHit = (bm == 3) || (bm == 1 && c == 1) || (bm == 2 && c == 0);
          startProg(32'd0); waitStop();
          chk("R9 irq count", irqCnt, iHit ? 1 : 0);
          chk("R10 branch target", lastFetch, bHit ? 32'h40 : 32'h10);
          chk("R10 BT bit", {31'd0, statusOut[8]}, {31'd0, bHit});
          chk("R11 nop no writeback", wbCnt, 0);
          chk("R11 nop no transfer", xferCnt, 0);
        end
      end
    end
    devStat = 0;

    // R12: chained descriptors
    clearMem();
    mem[0] = mkDesc(4'd0, 3'd0, 6'd0, 16'd8, 32'h100, 32'd0);
    mem[1] = mkDesc(4'd1, 3'd1, 6'd0, 16'd4, 32'h200, 32'd0);
    startProg(32'd0); waitStop();
    chk("R12 chained writebacks", wbCnt, 2);
    chk("R12 chained last wb addr", lastWbA, 32'h1C);
    chk("R11 stop leaves pointer", lastFetch, 32'h20);

    // R12: run low keeps channel idle
    runIn = 0;
    startProg(32'd0);
    repeat (20) @(negedge clk);
    chk("R12 no fetch while run low", fetchCnt, 0);
    chk("R2 go sets active", {31'd0, statusOut[10]}, 32'd1);
    runIn = 1;
    waitStop();
    chk("R12 runs after run high", wbCnt, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule